// File: doc/BRIEF.md
# Variable-Length Instruction Form Decoder

This block is the decode stage for a small register machine whose instructions are either one 16-bit halfword or two. It takes the first halfword together with the halfword that follows it. The two lowest bits of the first halfword select one of six physical forms:

- short register
- short immediate
- long with a 16-bit immediate
- long with a 20-bit immediate
- extended register
- extended immediate

From the selected form the block derives the opcode, both source register addresses, the result register, an extended immediate operand and an operand-is-immediate flag. It also produces the byte length, which the fetch unit uses to advance the program counter, and a form error flag. The raw predicate and pointer-update fields are passed through for later stages.

Decode is combinational. The results are captured in a single output register stage that is qualified by a valid bit. Three tables are parameters, each a 64-bit vector indexed by opcode: the opcodes that take a 20-bit immediate, the opcodes that are legal only as short instructions, and the opcodes that refuse any immediate operand. A further parameter names the shift and rotate opcode group by its top three opcode bits.

Top module: `form_decoder`

## Requirements
- R1: When bit 0 of the first halfword is 0, the output length is 2 bytes. When bit 0 is 1, the output length is 4 bytes.
- R2: The output form code is derived from the instruction bits as follows:
  - 0: short register form, bit 0 = 0 and bit 1 = 0.
  - 1: short immediate form, bit 0 = 0 and bit 1 = 1.
  - 2: long immediate form with a 16-bit immediate, bit 0 = 1 and bit 1 = 0, for an opcode not in the 20-bit table (default opcodes 1 and 2).
  - 3: long immediate form with a 20-bit immediate, same bits as form 2, for an opcode in the 20-bit table.
  - 4: extended register form, bits 1:0 = 11 and aux bit 20 = 0.
  - 5: extended immediate form, bits 1:0 = 11 and aux bit 20 = 1.
- R3: The opcode is taken from bits 7:2 and source B from bits 11:8, in every form.
- R4: The result register depends on the form:
  - short forms: bits 11:8.
  - long immediate forms: bits 15:12.
  - extended forms: bits 31:28.
- R5: In the short immediate form, the immediate is bits 15:12 sign-extended to DATA_W. For opcodes whose bits 5:3 equal 3'b010 (the shift group, opcodes 16 to 23) it is zero-extended, giving 0 to 15.
- R6: In form 2 the immediate is bits 31:16 sign-extended. In form 3 it is the 20-bit value {bits 11:8, bits 31:16} sign-extended.
- R7: In form 5 the immediate is {bits 19:18, bits 15:12} sign-extended from 6 bits, the update output is {2'b00, bits 17:16}, and aux is 1. In form 4 the update output is bits 19:16.
- R8: In extended forms the condition output is bits 27:21. In all other forms the condition, update and aux outputs are 0.
- R9: The immediate flag is 1 exactly in forms 1, 2, 3 and 5. Source A is bits 15:12 in forms 0 and 4 and is 0 otherwise. The immediate is 0 whenever the flag is 0.
- R10: For a short instruction, the second halfword has no effect on any output.
- R11: The error flag is set in either of two cases:
  - an opcode from the short-only table (default 60 to 63) arrives in a 4-byte form;
  - an opcode from the no-immediate table (default 40 to 43) arrives in forms 1, 2, 3 or 5.
- R12: The outputs change one clock after a cycle with in_valid high, and out_valid follows in_valid with that same one-cycle delay. When in_valid is low the outputs hold their values. Reset clears out_valid and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction words are valid this cycle |
| in_lo | input | 16 | First instruction halfword |
| in_hi | input | 16 | Following halfword, used only by 4-byte forms |
| out_valid | output | 1 | Decoded outputs are valid |
| out_form | output | 3 | Form code 0 to 5 |
| out_len | output | 3 | Instruction length in bytes (2 or 4) |
| out_opc | output | 6 | Opcode |
| out_src_a | output | 4 | Source A register address, or 0 |
| out_src_b | output | 4 | Source B register address |
| out_dst | output | 4 | Result register address |
| out_use_imm | output | 1 | Second operand is the immediate |
| out_imm | output | DATA_W | Extended immediate operand |
| out_cond | output | 7 | Raw predicate field |
| out_aux | output | 1 | Extended immediate sub-form flag |
| out_upd | output | 4 | Raw pointer-update field |
| out_err | output | 1 | Opcode not allowed in this form |

## Verification
The bench builds the block with its default parameters: DATA_W of 32, the shift group set to opcodes 16 to 23, and the default opcode tables. With these values every one of the 65536 first-halfword patterns is swept, each paired with a pseudo-random second halfword. That sweep reaches every form for every opcode, every sign of every immediate width, the shift-group unsigned case and every combination of the error tables. Directed cases then vary only the second halfword under a short instruction and exercise the hold behaviour when in_valid is low.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

  localparam int HALF_W = 16;
  localparam int OPC_W  = 6;
  localparam int RA_W   = 4;
  localparam int NUM_OPC = 1 << OPC_W;
  localparam int COND_W = 7;

  typedef enum logic [2:0] {
    FORM_SREG   = 3'd0,
    FORM_SIMM   = 3'd1,
    FORM_LIMM16 = 3'd2,
    FORM_LIMM20 = 3'd3,
    FORM_XREG   = 3'd4,
    FORM_XIMM   = 3'd5
  } form_e;

  // first halfword, MSB first
  typedef struct packed {
    logic [RA_W-1:0]  si4;
    logic [RA_W-1:0]  snd;
    logic [OPC_W-1:0] opc;
    logic             kind;   // bit 1
    logic             wide;   // bit 0
  } lo_fields_t;

  // second halfword of the extended form, MSB first
  typedef struct packed {
    logic [RA_W-1:0] dst;
    logic [3:0]      cnd;
    logic [2:0]      code;
    logic            aux;
    logic [3:0]      upd;
  } hi_fields_t;

  function automatic logic form_has_imm(input form_e f);
    return (f == FORM_SIMM) || (f == FORM_LIMM16) ||
           (f == FORM_LIMM20) || (f == FORM_XIMM);
  endfunction

  function automatic logic form_is_ext(input form_e f);
    return (f == FORM_XREG) || (f == FORM_XIMM);
  endfunction

endpackage

// File: rtl/fdec_opclass.sv
module fdec_opclass
  import fdec_pkg::*;
#(
  parameter logic [2:0]         SHIFT_GRP      = 3'b010,
  parameter logic [NUM_OPC-1:0] IMM20_SET      = 64'h0000_0000_0000_0006,
  parameter logic [NUM_OPC-1:0] SHORT_ONLY_SET = 64'hF000_0000_0000_0000,
  parameter logic [NUM_OPC-1:0] NOIMM_SET      = 64'h0000_0F00_0000_0000
) (
  input  logic [OPC_W-1:0] opc,
  output logic             is_shift,
  output logic             is_imm20,
  output logic             is_short_only,
  output logic             is_noimm
);

  logic [NUM_OPC-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_OPC; g++) begin : g_hit
      assign hit[g] = (opc == OPC_W'(g));
    end
  endgenerate

  assign is_shift      = (opc[OPC_W-1:OPC_W-3] == SHIFT_GRP);
  assign is_imm20      = |(hit & IMM20_SET);
  assign is_short_only = |(hit & SHORT_ONLY_SET);
  assign is_noimm      = |(hit & NOIMM_SET);

endmodule

// File: rtl/fdec_form_sel.sv
module fdec_form_sel
  import fdec_pkg::*;
(
  input  logic  wide,
  input  logic  kind,
  input  logic  aux,
  input  logic  is_imm20,
  input  logic  is_short_only,
  input  logic  is_noimm,
  output form_e form,
  output logic  form_err
);

  always_comb begin
    if (!wide)
      form = kind ? FORM_SIMM : FORM_SREG;
    else if (!kind)
      form = is_imm20 ? FORM_LIMM20 : FORM_LIMM16;
    else
      form = aux ? FORM_XIMM : FORM_XREG;
  end

  assign form_err = (is_short_only && wide) || (is_noimm && form_has_imm(form));

endmodule

// File: rtl/fdec_imm_gen.sv
module fdec_imm_gen
  import fdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  form_e              form,
  input  logic [RA_W-1:0]    si4,
  input  logic [RA_W-1:0]    snd,
  input  logic [HALF_W-1:0]  hi,
  input  logic               is_shift,
  output logic [DATA_W-1:0]  imm
);

  // sign-extend the low w bits of v
  function automatic logic [DATA_W-1:0] ext_s(input logic [19:0] v, input int w);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++)
      r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  // zero-extend the low w bits of v
  function automatic logic [DATA_W-1:0] ext_z(input logic [19:0] v, input int w);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++)
      r[i] = (i < w) ? v[i] : 1'b0;
    return r;
  endfunction

  always_comb begin
    case (form)
      FORM_SIMM:   imm = is_shift ? ext_z({16'd0, si4}, 4) : ext_s({16'd0, si4}, 4);
      FORM_LIMM16: imm = ext_s({4'd0, hi}, 16);
      FORM_LIMM20: imm = ext_s({snd, hi}, 20);
      FORM_XIMM:   imm = ext_s({14'd0, hi[3:2], si4}, 6);
      default:     imm = '0;
    endcase
  end

endmodule

// File: rtl/form_decoder.sv
module form_decoder
  import fdec_pkg::*;
#(
  parameter int                 DATA_W         = 32,
  parameter logic [2:0]         SHIFT_GRP      = 3'b010,
  parameter logic [NUM_OPC-1:0] IMM20_SET      = 64'h0000_0000_0000_0006,
  parameter logic [NUM_OPC-1:0] SHORT_ONLY_SET = 64'hF000_0000_0000_0000,
  parameter logic [NUM_OPC-1:0] NOIMM_SET      = 64'h0000_0F00_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_lo,
  input  logic [15:0]       in_hi,
  output logic              out_valid,
  output logic [2:0]        out_form,
  output logic [2:0]        out_len,
  output logic [5:0]        out_opc,
  output logic [3:0]        out_src_a,
  output logic [3:0]        out_src_b,
  output logic [3:0]        out_dst,
  output logic              out_use_imm,
  output logic [DATA_W-1:0] out_imm,
  output logic [6:0]        out_cond,
  output logic              out_aux,
  output logic [3:0]        out_upd,
  output logic              out_err
);

  localparam logic [2:0] LEN_SHORT = 3'd2;
  localparam logic [2:0] LEN_LONG  = 3'd4;

  lo_fields_t lf;
  hi_fields_t hf;
  assign lf = lo_fields_t'(in_lo);
  assign hf = hi_fields_t'(in_hi);

  // named internal events
  logic              dec_shift, dec_imm20, dec_short_only, dec_noimm;
  form_e             dec_form;
  logic              dec_err;
  logic [DATA_W-1:0] dec_imm;
  logic [RA_W-1:0]   dec_dst, dec_src_a;
  logic [COND_W-1:0] dec_cond;
  logic [3:0]        dec_upd;
  logic              dec_ext;

  fdec_opclass #(
    .SHIFT_GRP(SHIFT_GRP), .IMM20_SET(IMM20_SET),
    .SHORT_ONLY_SET(SHORT_ONLY_SET), .NOIMM_SET(NOIMM_SET)
  ) u_opclass (
    .opc(lf.opc), .is_shift(dec_shift), .is_imm20(dec_imm20),
    .is_short_only(dec_short_only), .is_noimm(dec_noimm)
  );

  fdec_form_sel u_form_sel (
    .wide(lf.wide), .kind(lf.kind), .aux(hf.aux),
    .is_imm20(dec_imm20), .is_short_only(dec_short_only), .is_noimm(dec_noimm),
    .form(dec_form), .form_err(dec_err)
  );

  fdec_imm_gen #(.DATA_W(DATA_W)) u_imm_gen (
    .form(dec_form), .si4(lf.si4), .snd(lf.snd), .hi(in_hi),
    .is_shift(dec_shift), .imm(dec_imm)
  );

  assign dec_ext = form_is_ext(dec_form);

  always_comb begin
    case (dec_form)
      FORM_SREG, FORM_SIMM:     dec_dst = lf.snd;
      FORM_LIMM16, FORM_LIMM20: dec_dst = lf.si4;
      default:                  dec_dst = hf.dst;
    endcase
  end

  assign dec_src_a = (dec_form == FORM_SREG || dec_form == FORM_XREG) ? lf.si4 : '0;
  assign dec_cond  = dec_ext ? {hf.cnd, hf.code} : '0;

  always_comb begin
    case (dec_form)
      FORM_XREG: dec_upd = hf.upd;
      FORM_XIMM: dec_upd = {2'b00, hf.upd[1:0]};
      default:   dec_upd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_form    <= '0;
      out_len     <= '0;
      out_opc     <= '0;
      out_src_a   <= '0;
      out_src_b   <= '0;
      out_dst     <= '0;
      out_use_imm <= 1'b0;
      out_imm     <= '0;
      out_cond    <= '0;
      out_aux     <= 1'b0;
      out_upd     <= '0;
      out_err     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_form    <= dec_form;
        out_len     <= lf.wide ? LEN_LONG : LEN_SHORT;
        out_opc     <= lf.opc;
        out_src_a   <= dec_src_a;
        out_src_b   <= lf.snd;
        out_dst     <= dec_dst;
        out_use_imm <= form_has_imm(dec_form);
        out_imm     <= dec_imm;
        out_cond    <= dec_cond;
        out_aux     <= (dec_form == FORM_XIMM);
        out_upd     <= dec_upd;
        out_err     <= dec_err;
      end
    end
  end

endmodule

// File: rtl/fdec_checker.sv
module fdec_checker #(
  parameter int         DATA_W    = 32,
  parameter logic [2:0] SHIFT_GRP = 3'b010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [2:0]        out_form,
  input logic [2:0]        out_len,
  input logic [5:0]        out_opc,
  input logic [3:0]        out_src_b,
  input logic [3:0]        out_dst,
  input logic              out_use_imm,
  input logic [DATA_W-1:0] out_imm,
  input logic [6:0]        out_cond,
  input logic              out_aux,
  input logic [3:0]        out_upd,
  input logic              out_err,
  input logic              dec_err,
  input logic              dec_ext
);

  p_len_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_len == 3'd4) == (out_form >= 3'd2)) && (out_len == 3'd2 || out_len == 3'd4));

  p_form_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_form <= 3'd5);

  p_short_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form <= 3'd1) |-> out_dst == out_src_b);

  p_simm_signed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 3'd1 && out_opc[5:3] != SHIFT_GRP) |->
      (out_imm[DATA_W-1:3] == '0 || out_imm[DATA_W-1:3] == '1));

  p_simm_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 3'd1 && out_opc[5:3] == SHIFT_GRP) |-> out_imm < DATA_W'(16));

  p_ctl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form < 3'd4) |-> (out_cond == '0 && out_upd == '0 && !out_aux));

  p_imm_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_use_imm) |-> out_imm == '0);

  p_reg_form_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 3'd0) |-> !out_err);

  p_err_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_err == $past(dec_err));

  p_cond_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_ext) |=> out_cond == '0);

  p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_imm) && $stable(out_form) && $stable(out_dst)));

endmodule

bind form_decoder fdec_checker #(.DATA_W(DATA_W), .SHIFT_GRP(SHIFT_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_form(out_form), .out_len(out_len), .out_opc(out_opc),
  .out_src_b(out_src_b), .out_dst(out_dst), .out_use_imm(out_use_imm),
  .out_imm(out_imm), .out_cond(out_cond), .out_aux(out_aux),
  .out_upd(out_upd), .out_err(out_err), .dec_err(dec_err), .dec_ext(dec_ext)
);

// File: tb/form_decoder_tb.sv
module form_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   in_lo = '0;
  logic [15:0]   in_hi = '0;
  logic          out_valid;
  logic [2:0]    out_form;
  logic [2:0]    out_len;
  logic [5:0]    out_opc;
  logic [3:0]    out_src_a, out_src_b, out_dst;
  logic          out_use_imm;
  logic [DW-1:0] out_imm;
  logic [6:0]    out_cond;
  logic          out_aux;
  logic [3:0]    out_upd;
  logic          out_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  form_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lo(in_lo), .in_hi(in_hi),
    .out_valid(out_valid), .out_form(out_form), .out_len(out_len), .out_opc(out_opc),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
    .out_use_imm(out_use_imm), .out_imm(out_imm), .out_cond(out_cond),
    .out_aux(out_aux), .out_upd(out_upd), .out_err(out_err)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected model from the requirements
  task automatic expect_all(input int lo, input int hi);
    int opc, si4, snd, form, imm, len, dst, srca, cond, upd, aux, useimm, err;
    opc = (lo / 4) % 64;
    snd = (lo / 256) % 16;
    si4 = (lo / 4096) % 16;
    if (lo % 2 == 0) begin
      len = 2;
      form = ((lo / 2) % 2 == 1) ? 1 : 0;
    end else begin
      len = 4;
      if ((lo / 2) % 2 == 0) form = (opc == 1 || opc == 2) ? 3 : 2;
      else form = ((hi / 16) % 2 == 1) ? 5 : 4;
    end
    useimm = (form == 1 || form == 2 || form == 3 || form == 5) ? 1 : 0;
    imm = 0;
    if (form == 1) begin
      if (opc >= 16 && opc <= 23) imm = si4;
      else imm = (si4 >= 8) ? si4 - 16 : si4;
    end else if (form == 2) begin
      imm = (hi >= 32768) ? hi - 65536 : hi;
    end else if (form == 3) begin
      imm = snd * 65536 + hi;
      if (imm >= 524288) imm = imm - 1048576;
    end else if (form == 5) begin
      imm = ((hi / 4) % 4) * 16 + si4;
      if (imm >= 32) imm = imm - 64;
    end
    if (form <= 1) dst = snd;
    else if (form <= 3) dst = si4;
    else dst = hi / 4096;
    srca = (form == 0 || form == 4) ? si4 : 0;
    cond = (form >= 4) ? (hi / 32) % 128 : 0;
    if (form == 4) upd = hi % 16;
    else if (form == 5) upd = hi % 4;
    else upd = 0;
    aux = (form == 5) ? 1 : 0;
    err = 0;
    if (opc >= 60 && len == 4) err = 1;
    if (opc >= 40 && opc <= 43 && useimm == 1) err = 1;

    chk("R12", "out_valid", out_valid, 1);
    chk("R1", "len", out_len, len);
    chk("R2", "form", out_form, form);
    chk("R3", "opc", out_opc, opc);
    chk("R3", "src_b", out_src_b, snd);
    chk("R4", "dst", out_dst, dst);
    if (form == 1) chk("R5", "imm4", out_imm, longint'(unsigned'(imm)));
    else if (form == 2 || form == 3) chk("R6", "imm16/20", out_imm, longint'(unsigned'(imm)));
    else if (form == 5) chk("R7", "imm6", out_imm, longint'(unsigned'(imm)));
    else chk("R9", "imm_zero", out_imm, 0);
    chk("R7", "upd", out_upd, upd);
    chk("R7", "aux", out_aux, aux);
    chk("R8", "cond", out_cond, cond);
    chk("R9", "use_imm", out_use_imm, useimm);
    chk("R9", "src_a", out_src_a, srca);
    chk("R11", "err", out_err, err);
  endtask

  // entered just after a falling edge; returns at the next falling edge
  task automatic apply(input int lo, input int hi);
    in_valid = 1'b1;
    in_lo = 16'(lo);
    in_hi = 16'(hi);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    logic [DW-1:0] held;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // reset state (R12)
    chk("R12", "reset out_valid", out_valid, 0);
    chk("R12", "reset imm", out_imm, 0);
    chk("R12", "reset form", out_form, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "idle out_valid", out_valid, 0);

    // targeted corners
    apply(16'h8001 | (6'd5 << 2), 16'h8000);            // long imm16, negative
    expect_all(16'h8001 | (6'd5 << 2), 16'h8000);
    apply(16'h0801 | (6'd1 << 2), 16'h0000);            // imm20 sign bit set (R6)
    expect_all(16'h0801 | (6'd1 << 2), 16'h0000);
    chk("R6", "imm20 most negative", out_imm, 32'hFFF8_0000);
    apply(16'hF002 | (6'd17 << 2), 16'h0000);           // shift group imm4=15 (R5)
    chk("R5", "shift imm unsigned", out_imm, 15);
    apply(16'hF002 | (6'd9 << 2), 16'h0000);            // signed imm4 = -1 (R5)
    chk("R5", "imm4 signed", out_imm, 32'hFFFF_FFFF);
    apply(16'h0003 | (6'd61 << 2), 16'h0000);           // short-only in ext (R11)
    chk("R11", "short-only wide err", out_err, 1);
    apply(16'h0003 | (6'd41 << 2), 16'h0000);           // no-imm in ext reg: legal
    chk("R11", "no-imm ext reg ok", out_err, 0);

    // R10: short instruction unaffected by second halfword
    for (int k = 0; k < 64; k++) begin
      int lo;
      logic [DW-1:0] i0;
      logic [3:0] d0;
      lo = (k * 1031 + 7) % 65536;
      lo = lo - (lo % 2);
      apply(lo, 16'h0000);
      i0 = out_imm; d0 = out_dst;
      apply(lo, 16'hFFFF);
      chk("R10", "short imm vs hi", out_imm, i0);
      chk("R10", "short dst vs hi", out_dst, d0);
      chk("R10", "short cond vs hi", out_cond, 0);
    end

    // R12 hold when in_valid low
    apply(16'h1235, 16'h7FFF);
    held = out_imm;
    in_valid = 1'b0;
    in_lo = 16'h0000;
    in_hi = 16'h8000;
    @(negedge clk);
    chk("R12", "valid drops", out_valid, 0);
    chk("R12", "imm holds", out_imm, held);

    // exhaustive sweep of the first halfword
    for (int w = 0; w < 65536; w++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(w, int'(lfsr));
      expect_all(w, int'(lfsr));
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule